// File: doc/BRIEF.md
# Time-Stamped Sparsified Pixel Readout

This block is the digital core of a pixel matrix for a collider vertex detector. During an acquisition window every pixel of a 64 by 64 array watches its own binary hit line. A shared slice counter advances once per time-slice tick. A pixel that sees its first hit of the window keeps the counter value of that moment as its time stamp. Any further hits on that pixel are ignored.

When the window closes, data taking stops and a sparsifier walks the array. It emits one word for each hit pixel only, carrying the pixel's row, column and stamp, on a valid/ready stream. A row with no hits costs a single cycle. A hit pixel costs one accepted beat. The frame ends with a single end-of-frame beat. Each pixel is cleared as its word is accepted, so the array is empty again when the frame ends. Only then does the block report that it is idle and accept the next window. Readout therefore never overlaps data taking.

Top module: `pix_readout_top`

## Requirements
- R1: After reset the block is idle (`idle`=1), `out_valid` is 0, and no pixel holds a hit.
- R2: A pixel hit in an accepted window stores the slice count at its first hit. The slice count is the number of `slice_tick` cycles seen in the window before that cycle. A tick in the same cycle as the hit is not counted for that hit.
- R3: The slice count saturates at 2^TS_W-1 and never wraps back to a smaller value within a window.
- R4: A later hit on a pixel that already holds a hit leaves the stored stamp unchanged and produces no extra word.
- R5: Hit inputs are ignored unless a window is open, both while idle and during readout.
- R6: Readout emits exactly one word per hit pixel and none for other pixels. The word is `out_data` = {row[RW-1:0], col[CW-1:0], stamp[TS_W-1:0]}, with the row in the top bits and the stamp in the bottom bits. Pixel (row, col) is driven by `hit_in[row*COLS+col]`.
- R7: Words leave in strictly ascending row-major order: rows ascending, and columns ascending within a row.
- R8: After the last word, exactly one beat with `out_eof`=1 and `out_data`=0 is emitted. Its acceptance returns the block to idle.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid`, `out_data` and `out_eof` unchanged, so no word is lost or repeated.
- R10: `win_start` opens a window only while `idle` is 1. It is ignored during acquisition and readout, and it restarts the slice count from 0.
- R11: A pixel read out in one frame is cleared, so a following window without hits produces only the end-of-frame beat.
- R12: `win_end` closes a window only while one is open. While idle it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Opens an acquisition window when idle |
| win_end | input | 1 | Closes the open window and starts readout |
| slice_tick | input | 1 | Advances the slice count during a window |
| hit_in | input | ROWS*COLS | Binary hit lines, bit row*COLS+col |
| out_valid | output | 1 | Stream word or end-of-frame beat present |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_data | output | RW+CW+TS_W | {row, col, stamp}; zero on end-of-frame |
| out_eof | output | 1 | Marks the end-of-frame beat |
| idle | output | 1 | Readout done; a new window may start |

## Verification
A stale or missed pixel flag appears as a wrong word count at the next frame. It shows either as a word that the model does not expect or as an end-of-frame beat that arrives while expected pixels are still pending. Both are caught at the handshake where the mismatch first happens. A corrupted slice count or stamp register shows as a wrong low field in the very word that carries it. A scan pointer that skips or rewinds breaks the row-major order or the stall-hold check within one or two cycles. A phase error shows at once on `idle` or on a stray `out_valid`.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int DEF_ROWS = 64;
    localparam int DEF_COLS = 64;
    localparam int DEF_TS_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    function automatic logic [DEF_TS_W-1:0] sat_step(input logic [DEF_TS_W-1:0] v);
        return (v == {DEF_TS_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pix_slice_counter.sv
module pix_slice_counter #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            inc,
    output logic [TS_W-1:0] ts
);
    localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            ts <= '0;
        else if (clr)
            ts <= '0;
        else if (inc && ts != TS_MAX)
            ts <= ts + 1'b1;
    end

    // R3: the count never moves backwards except on a window restart
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ts >= $past(ts));

    // R2: without a tick the count holds
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(ts));

endmodule

// File: rtl/pix_hit_matrix.sv
module pix_hit_matrix #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int TS_W = 5,
    parameter int RW   = 6,
    parameter int CW   = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acq_en,
    input  logic [ROWS*COLS-1:0] hit_in,
    input  logic [TS_W-1:0]      ts,
    input  logic                 clr_en,
    input  logic [RW-1:0]        clr_row,
    input  logic [CW-1:0]        clr_col,
    input  logic [RW-1:0]        rd_row,
    input  logic [CW-1:0]        rd_col,
    output logic [COLS-1:0]      row_bits,
    output logic [TS_W-1:0]      rd_stamp
);
    logic [COLS-1:0] flag_q  [ROWS];
    logic [TS_W-1:0] stamp_q [ROWS][COLS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                flag_q[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (acq_en && hit_in[r*COLS+c])
                        flag_q[r][c] <= 1'b1;
                    else if (clr_en && clr_row == RW'(r) && clr_col == CW'(c))
                        flag_q[r][c] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (acq_en && hit_in[r*COLS+c] && !flag_q[r][c])
                    stamp_q[r][c] <= ts;
            end
        end
    end

    assign row_bits = flag_q[rd_row];
    assign rd_stamp = stamp_q[rd_row][rd_col];

    // R6: a clear only ever targets a pixel that holds a hit
    p_clr_target_r6: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> (clr_row == rd_row && row_bits[clr_col]));

    // R4: a pixel that already holds a hit keeps its stamp
    p_first_keep_r4: assert property (@(posedge clk) disable iff (rst)
        flag_q[0][0] |=> stamp_q[0][0] == $past(stamp_q[0][0]));

    // R5: no pixel is set while acquisition is closed
    p_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (!acq_en && !flag_q[0][0]) |=> !flag_q[0][0]);

endmodule

// File: rtl/pix_sparsifier.sv
module pix_sparsifier #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int TS_W = 5,
    parameter int RW   = 6,
    parameter int CW   = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [COLS-1:0]       row_bits,
    input  logic [TS_W-1:0]       rd_stamp,
    output logic [RW-1:0]         rd_row,
    output logic [CW-1:0]         rd_col,
    output logic                  clr_en,
    output logic                  done,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [RW+CW+TS_W-1:0] out_data,
    output logic                  out_eof
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    logic [RW-1:0] row_q;
    logic          eof_q;
    logic          any_hit;
    logic [CW-1:0] first_col;

    always_comb begin
        first_col = '0;
        for (int c = COLS - 1; c >= 0; c--)
            if (row_bits[c])
                first_col = CW'(c);
    end

    assign any_hit   = |row_bits;
    assign rd_row    = row_q;
    assign rd_col    = first_col;
    assign out_valid = rd_en && (eof_q || any_hit);
    assign out_eof   = rd_en && eof_q;
    assign out_data  = (rd_en && !eof_q && any_hit) ? {row_q, first_col, rd_stamp} : '0;
    assign clr_en    = rd_en && !eof_q && any_hit && out_ready;
    assign done      = rd_en && eof_q && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            eof_q <= 1'b0;
        end else if (rd_en) begin
            if (eof_q) begin
                if (out_ready) begin
                    eof_q <= 1'b0;
                    row_q <= '0;
                end
            end else if (!any_hit) begin
                if (row_q == LAST_ROW)
                    eof_q <= 1'b1;
                else
                    row_q <= row_q + 1'b1;
            end
        end
    end

    // R9: a stalled beat is held unchanged
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    // R7: the word after an accepted word has a larger address
    p_order_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_eof) |=>
            (!out_valid || out_eof ||
             out_data[RW+CW+TS_W-1:TS_W] > $past(out_data[RW+CW+TS_W-1:TS_W])));

endmodule

// File: rtl/pix_readout_top.sv
module pix_readout_top
    import pix_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS,
    parameter int TS_W = DEF_TS_W,
    localparam int RW     = $clog2(ROWS),
    localparam int CW     = $clog2(COLS),
    localparam int WORD_W = RW + CW + TS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_start,
    input  logic                 win_end,
    input  logic                 slice_tick,
    input  logic [ROWS*COLS-1:0] hit_in,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_eof,
    output logic                 idle
);
    phase_e          phase_q;
    logic            open_win;
    logic            acq_en;
    logic            rd_en;
    logic            ro_done;
    logic [TS_W-1:0] ts;
    logic [COLS-1:0] row_bits;
    logic [TS_W-1:0] rd_stamp;
    logic [RW-1:0]   rd_row;
    logic [CW-1:0]   rd_col;
    logic            clr_en;

    assign open_win = (phase_q == PH_IDLE) && win_start;
    assign acq_en   = (phase_q == PH_ACQ);
    assign rd_en    = (phase_q == PH_READ);
    assign idle     = (phase_q == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_IDLE;
        else begin
            unique case (phase_q)
                PH_IDLE: if (win_start) phase_q <= PH_ACQ;
                PH_ACQ:  if (win_end)   phase_q <= PH_READ;
                PH_READ: if (ro_done)   phase_q <= PH_IDLE;
                default:                phase_q <= PH_IDLE;
            endcase
        end
    end

    pix_slice_counter #(.TS_W(TS_W)) i_counter (
        .clk (clk),
        .rst (rst),
        .clr (open_win),
        .inc (acq_en && slice_tick),
        .ts  (ts)
    );

    pix_hit_matrix #(
        .ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .RW(RW), .CW(CW)
    ) i_matrix (
        .clk      (clk),
        .rst      (rst),
        .acq_en   (acq_en),
        .hit_in   (hit_in),
        .ts       (ts),
        .clr_en   (clr_en),
        .clr_row  (rd_row),
        .clr_col  (rd_col),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .row_bits (row_bits),
        .rd_stamp (rd_stamp)
    );

    pix_sparsifier #(
        .ROWS(ROWS), .COLS(COLS), .TS_W(TS_W), .RW(RW), .CW(CW)
    ) i_sparse (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .row_bits  (row_bits),
        .rd_stamp  (rd_stamp),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .clr_en    (clr_en),
        .done      (ro_done),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_eof   (out_eof)
    );

    // R8: an accepted end-of-frame beat leads straight back to idle
    p_eof_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_eof) |=> (idle && !out_valid));

    // R10: the stream is silent outside readout
    p_silent_outside_r10: assert property (@(posedge clk) disable iff (rst)
        (idle || acq_en) |-> !out_valid);

    // R12: a close request while idle leaves the block idle
    p_end_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (idle && !win_start) |=> idle);

endmodule

// File: tb/test_pix_readout_top.sv
module test_pix_readout_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS   = 64;
    localparam int COLS   = 64;
    localparam int TS_W   = 5;
    localparam int NPIX   = ROWS * COLS;
    localparam int WORD_W = 6 + 6 + TS_W;
    localparam int TS_MAX = (1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic win_start, win_end, slice_tick, out_ready;
    logic [NPIX-1:0] hit_in;
    logic out_valid, out_eof, idle;
    logic [WORD_W-1:0] out_data;

    int checks = 0;
    int failures = 0;

    bit              ref_flag  [NPIX];
    logic [TS_W-1:0] ref_stamp [NPIX];
    int              model_ts;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_readout_top #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) i_pix_readout_top (
        .clk(clk), .rst(rst), .win_start(win_start), .win_end(win_end),
        .slice_tick(slice_tick), .hit_in(hit_in), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof), .idle(idle)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pix(input int r, input int c);
        return r * COLS + c;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word(input int idx);
        return {6'(idx / COLS), 6'(idx % COLS), ref_stamp[idx]};
    endfunction

    function automatic logic [NPIX-1:0] rand_hits(input int kmax);
        logic [NPIX-1:0] v = '0;
        int k = $urandom_range(kmax, 0);
        for (int j = 0; j < k; j++) v[$urandom_range(NPIX-1, 0)] = 1'b1;
        return v;
    endfunction

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // one acquisition cycle with model update (hits before tick)
    task automatic acq_cycle(input logic [NPIX-1:0] v, input bit tick, input bit stray_start);
        @(negedge clk);
        hit_in = v; slice_tick = tick; win_start = stray_start; win_end = 1'b0;
        for (int i = 0; i < NPIX; i++)
            if (v[i] && !ref_flag[i]) begin
                ref_flag[i] = 1'b1;
                ref_stamp[i] = TS_W'(model_ts);
            end
        if (tick && model_ts < TS_MAX) model_ts++;
    endtask

    task automatic open_window(input string req);
        @(negedge clk);
        check(idle === 1'b1, req, "idle before start", idle, 1);
        win_start = 1'b1; win_end = 1'b0; slice_tick = 1'b1;
        hit_in = rand_hits(6);   // R5: ignored at the opening edge
        model_ts = 0;
    endtask

    task automatic close_window();
        @(negedge clk);
        hit_in = '0; win_start = 1'b0; win_end = 1'b1; slice_tick = 1'b0;
    endtask

    task automatic readout(input string req);
        bit              prev_stall = 1'b0;
        logic [WORD_W-1:0] prev_data = '0;
        bit              prev_eof = 1'b0;
        int              p = 0;
        bit              fin = 1'b0;
        for (int n = 0; n < 20000 && !fin; n++) begin
            @(negedge clk);
            win_end    = ($urandom_range(3, 0) == 0);
            win_start  = ($urandom_range(3, 0) == 0);   // R10: ignored in readout
            slice_tick = $urandom_range(1, 0);
            hit_in     = rand_hits(4);                  // R5: ignored in readout
            out_ready  = ($urandom_range(2, 0) != 0);
            #1;
            if (prev_stall) begin
                check(out_valid === 1'b1, "R9", "valid held", out_valid, 1);
                check(out_data === prev_data && out_eof === prev_eof, "R9", "beat held",
                      out_data, prev_data);
            end
            if (out_valid && out_ready) begin
                if (out_eof) begin
                    int left = 0;
                    for (int i = p; i < NPIX; i++) if (ref_flag[i]) left++;
                    check(left == 0, "R8", {req, " eof after last word"}, left, 0);
                    check(out_data == '0, "R8", "eof data zero", out_data, 0);
                    fin = 1'b1;
                end else begin
                    while (p < NPIX && !ref_flag[p]) p++;
                    if (p >= NPIX)
                        check(1'b0, "R6", {req, " extra word"}, out_data, 0);
                    else begin
                        check(out_data === exp_word(p), "R6", {req, " word (R7 order, R2 stamp)"},
                              out_data, exp_word(p));
                        ref_flag[p] = 1'b0;
                        p++;
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_eof   = out_eof;
        end
        if (!fin) check(1'b0, "R8", {req, " no end-of-frame"}, 0, 1);
        @(negedge clk);
        hit_in = '0; win_start = 1'b0; win_end = 1'b0; slice_tick = 1'b0; out_ready = 1'b0;
        #1;
        check(idle === 1'b1, "R10", {req, " idle after frame"}, idle, 1);
        check(out_valid === 1'b0, "R10", "no valid after frame", out_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary_and_end();
    end

    initial begin
        logic [NPIX-1:0] v;
        void'($urandom(32'd12345));
        for (int i = 0; i < NPIX; i++) ref_flag[i] = 1'b0;
        rst = 1'b1; win_start = 0; win_end = 0; slice_tick = 0; out_ready = 0; hit_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(idle === 1'b1, "R1", "idle after reset", idle, 1);
        check(out_valid === 1'b0, "R1", "valid after reset", out_valid, 0);

        // R12: close request while idle has no effect; R5: idle hits ignored
        @(negedge clk); win_end = 1'b1; hit_in = rand_hits(20); slice_tick = 1'b1;
        @(negedge clk); win_end = 1'b0; hit_in = '0; slice_tick = 1'b0;
        #1;
        check(idle === 1'b1, "R12", "idle after stray close", idle, 1);
        check(out_valid === 1'b0, "R12", "no valid after stray close", out_valid, 0);

        // frame A: corners, first-hit rule (R4), stamps (R2)
        open_window("R2");
        v = '0; v[pix(0,0)] = 1; v[pix(63,63)] = 1;
        acq_cycle(v, 1'b1, 1'b0);
        acq_cycle('0, 1'b1, 1'b1);          // stray start ignored (R10)
        v = '0; v[pix(0,63)] = 1; v[pix(5,7)] = 1;
        acq_cycle(v, 1'b1, 1'b0);
        v = '0; v[pix(63,0)] = 1; v[pix(5,7)] = 1; v[pix(0,0)] = 1;   // repeats ignored (R4)
        acq_cycle(v, 1'b0, 1'b0);
        close_window();
        readout("R4");

        // frame B: saturation (R3)
        open_window("R3");
        for (int i = 0; i < 40; i++) acq_cycle('0, 1'b1, 1'b0);
        v = '0; v[pix(10,10)] = 1; v[pix(10,11)] = 1;
        acq_cycle(v, 1'b1, 1'b0);
        check(model_ts == TS_MAX, "R3", "model saturated", model_ts, TS_MAX);
        close_window();
        readout("R3");

        // frame C: no hits after earlier frames (R11), idle hits ignored (R5)
        @(negedge clk); hit_in = rand_hits(30);
        open_window("R11");
        acq_cycle('0, 1'b1, 1'b0);
        close_window();
        readout("R11");

        // frame D: full row in one cycle
        open_window("R7");
        acq_cycle('0, 1'b1, 1'b0);
        v = '0; for (int c = 0; c < COLS; c++) v[pix(17,c)] = 1;
        acq_cycle(v, 1'b1, 1'b0);
        v = '0; v[pix(17,3)] = 1; v[pix(16,63)] = 1;
        acq_cycle(v, 1'b0, 1'b0);
        close_window();
        readout("R7");

        // random frames
        for (int f = 0; f < 6; f++) begin
            open_window("R6");
            for (int i = 0; i < 80 + f * 40; i++)
                acq_cycle(rand_hits(3), ($urandom_range(9, 0) < 3), ($urandom_range(15, 0) == 0));
            close_window();
            readout("R6");
        end

        summary_and_end();
    end
endmodule